// File: doc/BRIEF.md
# JTAG Instruction Decode Unit

This block holds the 5-bit test instruction register next to a TAP state machine and turns the latched instruction into the controls that steer test and debug logic. The TAP sequencer supplies one-hot state strobes: IR capture/shift/update, DR capture/shift/update, and the Test-Logic-Reset state. The unit shifts the new instruction in from TDI on rising TCK and makes it active on falling TCK during Update-IR. From the active instruction it drives a path code that tells the surrounding TDO multiplexer which data register sits between TDI and TDO. It also drives pin-control outputs (drive pins from boundary-scan cells, float all pins), an internal system reset and per-module debug enable and request vectors.

Two small data registers live inside the unit because its own decode depends on them. The first is a sticky debug-module selection register, which limits every later debug enable and request to the chosen modules. The second is a general-purpose register whose writes are limited by a bit mask. A one-bit bypass register is also kept here. The boundary-scan cells, the identification register and the debug register contents are outside the unit. It only names which of them is connected.

Top module: `tap_instr_decoder`

## Requirements
- R1: After trst_n low, or on a falling TCK edge with tlr high, the active instruction is 11111 (bypass). dr_path reads 0 and every side-effect control is released. dbg_select returns to all ones. The general-purpose register is cleared by trst_n only.
- R2: On rising TCK, cap_ir loads the IR shift stage with 00001. shf_ir shifts right, with tdi entering bit 4. ir_so always shows bit 0 of the shift stage.
- R3: The active instruction, and every output decoded from it, changes only on a falling TCK edge with upd_ir high (or tlr). Capturing and shifting the IR leave it untouched.
- R4: dr_path is encoded as 0 bypass, 1 boundary scan, 2 identification, 3 debug, 4 module selection and 5 general-purpose. Codes 00000 and 00001 give 1, code 00010 gives 2, codes 00110 and 00111 give 3, code 01001 gives 4 and code 01101 gives 5. drive_from_bsr is high for code 00000.
- R5: Code 00011 gives dr_path 0, drive_from_bsr high and sys_rst high, for as long as it is the active instruction.
- R6: Code 00100 gives dr_path 0, pins_hiz high, sys_rst high and drive_from_bsr low.
- R7: Code 00110 gives dbg_enable equal to dbg_select and dbg_request all zero.
- R8: Code 00111 gives dbg_enable and dbg_request both equal to dbg_select. No other code raises any dbg_request bit.
- R9: While code 01001 is active, cap_dr loads the selection shift stage from dbg_select, and shf_dr shifts it right with tdi entering the MSB. On falling TCK, upd_dr copies it into dbg_select, whatever the earlier selection was.
- R10: While code 01101 is active, the DR strobes work the same way on the general-purpose shift stage. On upd_dr, only the bits set in GPR_MASK take the shifted value; all other bits of gpr_q keep their value.
- R11: Every code not listed in R4 to R10 gives dr_path 0 with all side-effect controls low. This includes the reserved, private and 1xxxx codes.
- R12: loc_so shows bit 0 of whichever local register dr_path selects. The bypass register captures 0 and then shifts tdi. For dr_path values 1, 2 and 3, loc_so is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| cap_ir | input | 1 | Capture-IR strobe |
| shf_ir | input | 1 | Shift-IR strobe |
| upd_ir | input | 1 | Update-IR strobe |
| cap_dr | input | 1 | Capture-DR strobe |
| shf_dr | input | 1 | Shift-DR strobe |
| upd_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial test data in |
| ir_so | output | 1 | IR serial out |
| loc_so | output | 1 | Serial out of the selected local data register |
| dr_path | output | 3 | Selected data register code |
| drive_from_bsr | output | 1 | Pins driven from boundary-scan cells |
| pins_hiz | output | 1 | All output drivers off |
| sys_rst | output | 1 | Internal system reset |
| dbg_enable | output | NMOD | Debug path enable per module |
| dbg_request | output | NMOD | Debug request per module |
| dbg_select | output | NMOD | Sticky debug-module selection |
| gpr_q | output | GPR_W | General-purpose register value |

## Verification
The assertions assume that the TAP strobes are mutually exclusive, that each one is stable for a whole TCK period, and that the strobes change only while TCK is high, between a rising and the next falling edge. The bench keeps to this by driving every strobe and tdi 5 ns after a rising edge from a single task, with at most one strobe high per cycle. Test-Logic-Reset is raised on its own, never together with an update. The behavioural model in the bench applies update-side effects at the falling edge and shift-side effects at the rising edge, which matches that stimulus discipline.

// File: rtl/tid_pkg.sv
package tid_pkg;
  localparam int unsigned IR_W = 5;

  typedef enum logic [2:0] {
    PATH_BYP = 3'd0,
    PATH_BSR = 3'd1,
    PATH_ID  = 3'd2,
    PATH_DBG = 3'd3,
    PATH_SEL = 3'd4,
    PATH_GPR = 3'd5
  } path_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 5'b00000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 5'b00001;
  localparam logic [IR_W-1:0] OP_IDCODE  = 5'b00010;
  localparam logic [IR_W-1:0] OP_CLAMP   = 5'b00011;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 5'b00100;
  localparam logic [IR_W-1:0] OP_DBG     = 5'b00110;
  localparam logic [IR_W-1:0] OP_DBGREQ  = 5'b00111;
  localparam logic [IR_W-1:0] OP_CHOOSE  = 5'b01001;
  localparam logic [IR_W-1:0] OP_GPR     = 5'b01101;
  localparam logic [IR_W-1:0] OP_BYPASS  = 5'b11111;
  localparam logic [IR_W-1:0] CAP_PATTERN = 5'b00001;

  typedef struct packed {
    path_e path;
    logic  drive_bsr;
    logic  hiz;
    logic  sys_rst;
    logic  dbg_on;
    logic  dbg_req;
  } ctl_t;

  // Map an active instruction to its path and side-effect controls.
  function automatic ctl_t decode_op(input logic [IR_W-1:0] op);
    ctl_t c;
    c = '{path: PATH_BYP, drive_bsr: 1'b0, hiz: 1'b0, sys_rst: 1'b0,
          dbg_on: 1'b0, dbg_req: 1'b0};
    case (op)
      OP_EXTEST: begin c.path = PATH_BSR; c.drive_bsr = 1'b1; end
      OP_SAMPLE: c.path = PATH_BSR;
      OP_IDCODE: c.path = PATH_ID;
      OP_CLAMP:  begin c.drive_bsr = 1'b1; c.sys_rst = 1'b1; end
      OP_HIGHZ:  begin c.hiz = 1'b1; c.sys_rst = 1'b1; end
      OP_DBG:    begin c.path = PATH_DBG; c.dbg_on = 1'b1; end
      OP_DBGREQ: begin c.path = PATH_DBG; c.dbg_on = 1'b1; c.dbg_req = 1'b1; end
      OP_CHOOSE: c.path = PATH_SEL;
      OP_GPR:    c.path = PATH_GPR;
      default:   c.path = PATH_BYP;
    endcase
    return c;
  endfunction

  // Masked merge used for register updates.
  function automatic logic [63:0] merge_masked(input logic [63:0] old_v,
                                               input logic [63:0] new_v,
                                               input logic [63:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/tid_ir_stage.sv
module tid_ir_stage
  import tid_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tlr,
  input  logic            cap,
  input  logic            shf,
  input  logic            upd,
  input  logic            tdi,
  output logic            so,
  output logic [IR_W-1:0] act,
  output logic            upd_ev
);
  logic [IR_W-1:0] sh_q;

  assign upd_ev = upd & ~tlr;
  assign so     = sh_q[0];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)  sh_q <= '0;
    else if (cap) sh_q <= CAP_PATTERN;
    else if (shf) sh_q <= {tdi, sh_q[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     act <= OP_BYPASS;
    else if (tlr)    act <= OP_BYPASS;
    else if (upd_ev) act <= sh_q;
  end
endmodule

// File: rtl/tid_shadow_reg.sv
module tid_shadow_reg #(
  parameter int unsigned W        = 4,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] WR_MASK = '1
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         sel,
  input  logic         cap,
  input  logic         shf,
  input  logic         upd,
  input  logic         clr,
  input  logic         tdi,
  output logic         so,
  output logic [W-1:0] q
);
  logic [W-1:0] sh_q;
  logic [63:0]  merged;

  assign so     = sh_q[0];
  assign merged = tid_pkg::merge_masked(64'(q), 64'(sh_q), 64'(WR_MASK));

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         sh_q <= '0;
    else if (sel && cap) sh_q <= q;
    else if (sel && shf) sh_q <= {tdi, sh_q[W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)         q <= RST_VAL;
    else if (clr)        q <= RST_VAL;
    else if (sel && upd) q <= merged[W-1:0];
  end
endmodule

// File: rtl/tap_instr_decoder.sv
module tap_instr_decoder
  import tid_pkg::*;
#(
  parameter int unsigned NMOD = 4,
  parameter int unsigned GPR_W = 8,
  parameter logic [GPR_W-1:0] GPR_MASK = 8'h3C
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tlr,
  input  logic             cap_ir,
  input  logic             shf_ir,
  input  logic             upd_ir,
  input  logic             cap_dr,
  input  logic             shf_dr,
  input  logic             upd_dr,
  input  logic             tdi,
  output logic             ir_so,
  output logic             loc_so,
  output logic [2:0]       dr_path,
  output logic             drive_from_bsr,
  output logic             pins_hiz,
  output logic             sys_rst,
  output logic [NMOD-1:0]  dbg_enable,
  output logic [NMOD-1:0]  dbg_request,
  output logic [NMOD-1:0]  dbg_select,
  output logic [GPR_W-1:0] gpr_q
);
  localparam logic [NMOD-1:0] SEL_ALL = '1;

  logic [IR_W-1:0] ir_act;
  logic            ir_upd_ev;
  ctl_t            ctl;
  logic            on_byp, on_sel, on_gpr;
  logic            byp_q, sel_so, gpr_so;

  tid_ir_stage u_ir (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .cap(cap_ir), .shf(shf_ir),
    .upd(upd_ir), .tdi(tdi), .so(ir_so), .act(ir_act), .upd_ev(ir_upd_ev)
  );

  assign ctl    = decode_op(ir_act);
  assign on_byp = (ctl.path == PATH_BYP);
  assign on_sel = (ctl.path == PATH_SEL);
  assign on_gpr = (ctl.path == PATH_GPR);

  assign dr_path        = ctl.path;
  assign drive_from_bsr = ctl.drive_bsr;
  assign pins_hiz       = ctl.hiz;
  assign sys_rst        = ctl.sys_rst;

  tid_shadow_reg #(.W(NMOD), .RST_VAL(SEL_ALL), .WR_MASK(SEL_ALL)) u_sel (
    .tck(tck), .trst_n(trst_n), .sel(on_sel), .cap(cap_dr), .shf(shf_dr),
    .upd(upd_dr), .clr(tlr), .tdi(tdi), .so(sel_so), .q(dbg_select)
  );

  tid_shadow_reg #(.W(GPR_W), .RST_VAL('0), .WR_MASK(GPR_MASK)) u_gpr (
    .tck(tck), .trst_n(trst_n), .sel(on_gpr), .cap(cap_dr), .shf(shf_dr),
    .upd(upd_dr), .clr(1'b0), .tdi(tdi), .so(gpr_so), .q(gpr_q)
  );

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)               byp_q <= 1'b0;
    else if (on_byp && cap_dr) byp_q <= 1'b0;
    else if (on_byp && shf_dr) byp_q <= tdi;
  end

  always_comb begin
    case (ctl.path)
      PATH_BYP: loc_so = byp_q;
      PATH_SEL: loc_so = sel_so;
      PATH_GPR: loc_so = gpr_so;
      default:  loc_so = 1'b0;
    endcase
  end

  for (genvar m = 0; m < NMOD; m++) begin : g_mod
    assign dbg_enable[m]  = ctl.dbg_on  & dbg_select[m];
    assign dbg_request[m] = ctl.dbg_req & dbg_select[m];
  end
endmodule

// File: rtl/tap_instr_decoder_chk.sv
module tap_instr_decoder_chk #(
  parameter int unsigned NMOD = 4,
  parameter int unsigned GPR_W = 8,
  parameter logic [GPR_W-1:0] GPR_MASK = 8'h3C
) (
  input logic             tck,
  input logic             trst_n,
  input logic             tlr,
  input logic             cap_ir,
  input logic             upd_ir,
  input logic             ir_so,
  input logic [4:0]       ir_act,
  input logic [2:0]       dr_path,
  input logic             drive_from_bsr,
  input logic             pins_hiz,
  input logic             sys_rst,
  input logic [NMOD-1:0]  dbg_enable,
  input logic [NMOD-1:0]  dbg_request,
  input logic [NMOD-1:0]  dbg_select,
  input logic [GPR_W-1:0] gpr_q
);
  assert_tlr_defaults_R1: assert property (@(negedge tck) disable iff (!trst_n)
    tlr |=> (ir_act == 5'b11111 && dbg_select == '1));

  assert_capture_pattern_R2: assert property (@(posedge tck) disable iff (!trst_n)
    cap_ir |=> ir_so);

  assert_act_holds_R3: assert property (@(negedge tck) disable iff (!trst_n)
    (!upd_ir && !tlr) |=> $stable(ir_act));

  assert_reset_on_bypass_R5: assert property (@(negedge tck) disable iff (!trst_n)
    sys_rst |-> dr_path == 3'd0);

  assert_hiz_controls_R6: assert property (@(negedge tck) disable iff (!trst_n)
    pins_hiz |-> (sys_rst && !drive_from_bsr));

  assert_req_scope_R8: assert property (@(negedge tck) disable iff (!trst_n)
    (|dbg_request) |-> (dr_path == 3'd3 && (dbg_request & ~dbg_select) == '0
                        && dbg_request == dbg_enable));

  assert_gpr_masked_R10: assert property (@(negedge tck) disable iff (!trst_n)
    1'b1 |=> $stable(gpr_q & ~GPR_MASK));
endmodule

bind tap_instr_decoder tap_instr_decoder_chk #(
  .NMOD(NMOD), .GPR_W(GPR_W), .GPR_MASK(GPR_MASK)
) chk_i (
  .tck(tck), .trst_n(trst_n), .tlr(tlr), .cap_ir(cap_ir), .upd_ir(upd_ir),
  .ir_so(ir_so), .ir_act(ir_act), .dr_path(dr_path),
  .drive_from_bsr(drive_from_bsr), .pins_hiz(pins_hiz), .sys_rst(sys_rst),
  .dbg_enable(dbg_enable), .dbg_request(dbg_request),
  .dbg_select(dbg_select), .gpr_q(gpr_q)
);

// File: tb/tap_instr_decoder_tb_top.sv
`timescale 1ns/1ps
module tap_instr_decoder_tb_top;
  localparam int NMOD = 4;
  localparam int GPR_W = 8;
  localparam int MASK = 'h3C;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tlr = 0, cap_ir = 0, shf_ir = 0, upd_ir = 0;
  logic cap_dr = 0, shf_dr = 0, upd_dr = 0, tdi = 0;
  logic ir_so, loc_so, drive_from_bsr, pins_hiz, sys_rst;
  logic [2:0] dr_path;
  logic [NMOD-1:0] dbg_enable, dbg_request, dbg_select;
  logic [GPR_W-1:0] gpr_q;

  int compared = 0;
  int mismatched = 0;

  always #10 tck = ~tck;

  tap_instr_decoder dut_i (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .cap_ir(cap_ir), .shf_ir(shf_ir),
    .upd_ir(upd_ir), .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr),
    .tdi(tdi), .ir_so(ir_so), .loc_so(loc_so), .dr_path(dr_path),
    .drive_from_bsr(drive_from_bsr), .pins_hiz(pins_hiz), .sys_rst(sys_rst),
    .dbg_enable(dbg_enable), .dbg_request(dbg_request),
    .dbg_select(dbg_select), .gpr_q(gpr_q)
  );

  // Behavioural model state
  int m_irsh, m_act, m_sel, m_gpr, m_byp, m_selsh, m_gprsh;

  function automatic int want_path(input int op);
    if (op == 0 || op == 1) return 1;
    if (op == 2) return 2;
    if (op == 6 || op == 7) return 3;
    if (op == 9) return 4;
    if (op == 13) return 5;
    return 0;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    int p;
    bit listed;
    p = want_path(m_act);
    listed = (m_act inside {0, 1, 2, 3, 4, 6, 7, 9, 13});
    check("R2 ir_so", int'(ir_so), m_irsh & 1);
    check(listed ? "R4 dr_path" : "R11 dr_path", int'(dr_path), p);
    check("R5 drive_from_bsr", int'(drive_from_bsr), (m_act == 0 || m_act == 3) ? 1 : 0);
    check("R6 pins_hiz", int'(pins_hiz), (m_act == 4) ? 1 : 0);
    check("R5 sys_rst", int'(sys_rst), (m_act == 3 || m_act == 4) ? 1 : 0);
    check("R7 dbg_enable", int'(dbg_enable), (m_act == 6 || m_act == 7) ? m_sel : 0);
    check("R8 dbg_request", int'(dbg_request), (m_act == 7) ? m_sel : 0);
    check("R9 dbg_select", int'(dbg_select), m_sel);
    check("R10 gpr_q", int'(gpr_q), m_gpr);
    check("R12 loc_so", int'(loc_so),
          (p == 0) ? m_byp : (p == 4) ? (m_selsh & 1) : (p == 5) ? (m_gprsh & 1) : 0);
  endtask

  // Reference model, compared just before every rising edge
  initial begin
    forever begin
      @(negedge tck);
      #1;
      if (!trst_n) begin
        m_irsh = 0; m_act = 31; m_sel = 15; m_gpr = 0;
        m_byp = 0; m_selsh = 0; m_gprsh = 0;
      end else begin
        if (tlr) m_sel = 15;
        else if (upd_dr && m_act == 9) m_sel = m_selsh;
        if (upd_dr && m_act == 13) m_gpr = (m_gpr & ~MASK) | (m_gprsh & MASK);
        if (tlr) m_act = 31;
        else if (upd_ir) m_act = m_irsh;
      end
      #8;
      if (trst_n) compare_all();
      @(posedge tck);
      if (trst_n) begin
        if (cap_ir) m_irsh = 1;
        else if (shf_ir) m_irsh = (m_irsh >> 1) | (int'(tdi) << 4);
        case (want_path(m_act))
          0: if (cap_dr) m_byp = 0; else if (shf_dr) m_byp = int'(tdi);
          4: if (cap_dr) m_selsh = m_sel;
             else if (shf_dr) m_selsh = (m_selsh >> 1) | (int'(tdi) << 3);
          5: if (cap_dr) m_gprsh = m_gpr;
             else if (shf_dr) m_gprsh = (m_gprsh >> 1) | (int'(tdi) << 7);
          default: ;
        endcase
      end
    end
  end

  task automatic cyc(input logic ci, si, ui, cd, sd, ud, t, d);
    @(posedge tck);
    #5;
    cap_ir = ci; shf_ir = si; upd_ir = ui;
    cap_dr = cd; shf_dr = sd; upd_dr = ud; tlr = t; tdi = d;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic shift_ir(input int code, input bit do_upd);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, 0, 0, code[i]);
    if (do_upd) cyc(0, 0, 1, 0, 0, 0, 0, 0);
    idle();
  endtask

  task automatic shift_dr(input int width, input int val);
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < width; i++) cyc(0, 0, 0, 0, 1, 0, 0, val[i]);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    idle();
  endtask

  task automatic settle();
    @(negedge tck);
    #9;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge tck);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge tck);
    #5 trst_n = 1'b1;
    idle();
    settle();
    // R1 reset state
    check("R1 dr_path", int'(dr_path), 0);
    check("R1 dbg_select", int'(dbg_select), 15);
    check("R1 gpr_q", int'(gpr_q), 0);
    check("R1 sys_rst", int'(sys_rst), 0);

    // Sweep all codes: R4, R5, R6, R7, R8, R11
    for (int c = 0; c < 32; c++) shift_ir(c, 1'b1);

    // R3: shift without update keeps HIGHZ active
    shift_ir(4, 1'b1);
    shift_ir(2, 1'b0);
    settle();
    check("R3 pins_hiz held", int'(pins_hiz), 1);
    check("R3 dr_path held", int'(dr_path), 0);

    // R9: choose modules, then request debug
    shift_ir(9, 1'b1);
    shift_dr(4, 4'b0101);
    shift_ir(7, 1'b1);
    settle();
    check("R9 dbg_request scoped", int'(dbg_request), 4'b0101);
    shift_ir(9, 1'b1);
    shift_dr(4, 4'b0010);
    shift_ir(6, 1'b1);
    settle();
    check("R9 reselect", int'(dbg_enable), 4'b0010);

    // R1: Test-Logic-Reset restores defaults
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    idle();
    settle();
    check("R1 tlr dbg_select", int'(dbg_select), 15);
    check("R1 tlr dr_path", int'(dr_path), 0);
    check("R1 tlr dbg_enable", int'(dbg_enable), 0);

    // R10: masked general-purpose writes
    shift_ir(13, 1'b1);
    shift_dr(8, 8'hFF);
    settle();
    check("R10 gpr all ones", int'(gpr_q), 8'h3C);
    shift_dr(8, 8'hA5);
    settle();
    check("R10 gpr pattern", int'(gpr_q), 8'h24);

    // R12: bypass path serial behaviour
    shift_ir(31, 1'b1);
    shift_dr(6, 6'b101101);
    shift_ir(1, 1'b1);
    shift_dr(3, 3'b111);

    repeat (3) idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule